// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block turns a latch of display bits into per-pin drive level codes for a multiplexed liquid-crystal panel. It drives three common pins, one dual pin and 76 segment pins in total. The dual pin at segment index 73 is the fourth common in four-common mode and an ordinary segment in three-common mode. Each output is a 2-bit code that names one rung of a resistor ladder: ground, low tap, high tap or full. The analog ladder itself sits outside the block. Common count, bias, a blanking bit and a port-select count are all inputs, and the block samples them together with the display bits.

An oscillator enable tick paces the sequencer. One frame lasts `FRAME_TICKS` ticks and splits into two halves of N equal common slots, where N is 3 or 4. The second half repeats the first with mirrored levels, so the panel sees no net DC. Up to eight of the lowest segment pins can become static port outputs. A hold input blanks everything, and a sleep input darkens the panel while the ports stay live.

The control is one state machine with four states. HOLD is entered from any state while `hold_i` is high and is the state out of reset. HOLD goes to IDLE once hold drops. IDLE goes to SLEEP when sleep is set, or else to DRIVE on the next tick. DRIVE goes to SLEEP when sleep is set. SLEEP goes back to IDLE when sleep clears.

Top module: `lcdseq_top`

## Requirements
- R1: While reset or `hold_i` is applied, and from the clock edge after `hold_i` is sampled high, every common and segment code is 0, port pins included.
- R2: In DRIVE, a frame takes `FRAME_TICKS` counted ticks, split into 2N equal slots. Common c (0-based) is selected in slots c and N+c. Slots 0..N-1 form the positive half and slots N..2N-1 the negative half.
- R3: `duty_i`=0 selects four commons, and the dual pin (segment index 73) then carries the fourth common waveform. `duty_i`=1 selects three commons, and the dual pin is then an ordinary segment.
- R4: With `bias_i`=0 (third bias) the codes are as follows. In the positive half: selected common 3, other commons 1, lit segment 0, dark segment 2. In the negative half: selected common 0, other commons 2, lit segment 3, dark segment 1.
- R5: With `bias_i`=1 (half bias), every code that is neither a selected common nor a lit segment is 1. The extremes are the same as in R4.
- R6: Segment pin j uses slot index k=j, except in four-common mode for pins above 73, where k=j-1. While common c is selected, the pin is lit when display bit `disp_i[k*N+c]` is 1.
- R7: With `segoff_i`=1, every segment pin that is not a port drives the dark level of R4 or R5, and the commons keep scanning.
- R8: While in SLEEP, all common pins and all non-port segment pins are 0. Port pins keep following the display bits. Clearing sleep restarts the frame at slot 0.
- R9: `psel_i`=p turns the lowest min(p,8) segment pins into ports. Port pin j outputs 3 when `disp_i[j*N]` is 1 and 0 otherwise, in every state except HOLD.
- R10: In DRIVE, display bits and mode inputs are taken only at the frame boundary (slot 2N-1 ending). In IDLE and SLEEP they are taken on every clock.
- R11: The slot and tick counters advance only on clocks where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oscillator enable tick |
| hold_i | input | 1 | Display reset hold, active high |
| sleep_i | input | 1 | Sleep request |
| duty_i | input | 1 | 0: four commons, 1: three commons |
| bias_i | input | 1 | 0: third bias, 1: half bias |
| segoff_i | input | 1 | Force all segments dark |
| psel_i | input | 4 | Number of low segment pins used as ports |
| disp_i | input | 300 | Latched display bits |
| com_o | output | 6 | Level codes of commons 0..2, 2 bits each |
| seg_o | output | 152 | Level codes of segment pins 0..75, 2 bits each |

## Verification
The bench targets the dual pin in both common counts and the shifted slot index of the pins above it. A design that got these wrong would scan a fourth common onto a segment, or display every upper segment one column off. Data is swapped in mid-frame, and the bench samples just before and just after the boundary. Tearing at that point would show new bits four slots too early. Ticks are withheld for hundreds of clocks to catch a free-running counter. The checks also cover sleep with live ports, a port count above eight, and blanking that still leaves ports static. A wrong design there would freeze the ports, drop or wrap the ports past eight, or blank the ports too.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    typedef enum logic [1:0] {
        LV_GND = 2'd0,
        LV_LO  = 2'd1,
        LV_HI  = 2'd2,
        LV_TOP = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_DRIVE = 2'd2,
        ST_SLEEP = 2'd3
    } state_e;

    // common pin level: selected takes an extreme, others a middle tap
    function automatic lvl_e lvl_com(input logic sel, input logic neg, input logic half);
        if (sel)
            return neg ? LV_GND : LV_TOP;
        else if (half)
            return LV_LO;
        else
            return neg ? LV_HI : LV_LO;
    endfunction

    // segment pin level: a lit dot sits opposite the selected common
    function automatic lvl_e lvl_seg(input logic lit, input logic neg, input logic half);
        if (lit)
            return neg ? LV_TOP : LV_GND;
        else if (half)
            return LV_LO;
        else
            return neg ? LV_LO : LV_HI;
    endfunction

endpackage

// File: rtl/lcdseq_timer.sv
module lcdseq_timer #(
    parameter int FRAME_TICKS = 384
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic       four_i,
    output logic [1:0] com_idx_o,
    output logic       neg_o,
    output logic       frame_end_o
);
    localparam int SLOT3 = FRAME_TICKS / 6;
    localparam int SLOT4 = FRAME_TICKS / 8;
    localparam int TW    = $clog2(SLOT3);

    logic [TW-1:0] tcnt_q;
    logic [2:0]    slot_q;
    logic          slot_end;
    logic [2:0]    last_slot;

    assign slot_end    = four_i ? (tcnt_q == TW'(SLOT4 - 1)) : (tcnt_q == TW'(SLOT3 - 1));
    assign last_slot   = four_i ? 3'd7 : 3'd5;
    assign frame_end_o = run_i && tick_i && slot_end && (slot_q == last_slot);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            slot_q <= '0;
        end else if (!run_i) begin
            tcnt_q <= '0;
            slot_q <= '0;
        end else if (tick_i) begin
            if (slot_end) begin
                tcnt_q <= '0;
                slot_q <= (slot_q == last_slot) ? 3'd0 : slot_q + 3'd1;
            end else begin
                tcnt_q <= tcnt_q + TW'(1);
            end
        end
    end

    always_comb begin
        if (four_i) begin
            com_idx_o = slot_q[1:0];
            neg_o     = slot_q[2];
        end else if (slot_q >= 3'd3) begin
            com_idx_o = 2'(slot_q - 3'd3);
            neg_o     = 1'b1;
        end else begin
            com_idx_o = slot_q[1:0];
            neg_o     = 1'b0;
        end
    end

    // R11: no tick, no movement
    a_r11_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> ($stable(slot_q) && $stable(tcnt_q)));

    // R2: slot index stays inside the 2N-slot frame
    a_r2_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= (four_i ? 3'd7 : 3'd5));

endmodule

// File: rtl/lcdseq_shadow.sv
module lcdseq_shadow #(
    parameter int DBITS  = 300,
    parameter int PSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [DBITS-1:0]  disp_i,
    input  logic              duty_i,
    input  logic              bias_i,
    input  logic              segoff_i,
    input  logic [PSEL_W-1:0] psel_i,
    output logic [DBITS-1:0]  disp_o,
    output logic              four_o,
    output logic              half_o,
    output logic              segoff_o,
    output logic [PSEL_W-1:0] psel_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_o   <= '0;
            four_o   <= 1'b1;
            half_o   <= 1'b0;
            segoff_o <= 1'b0;
            psel_o   <= '0;
        end else if (clr_i) begin
            disp_o   <= '0;
            four_o   <= 1'b1;
            half_o   <= 1'b0;
            segoff_o <= 1'b0;
            psel_o   <= '0;
        end else if (load_i) begin
            disp_o   <= disp_i;
            four_o   <= ~duty_i;
            half_o   <= bias_i;
            segoff_o <= segoff_i;
            psel_o   <= psel_i;
        end
    end

    // R10: drive copy only moves when a load or clear is granted
    a_r10_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clr_i) |=> ($stable(disp_o) && $stable(four_o) && $stable(half_o)));

endmodule

// File: rtl/lcdseq_pinmap.sv
module lcdseq_pinmap
    import lcdseq_pkg::*;
#(
    parameter int NSEG   = 76,
    parameter int NPORT  = 8,
    parameter int DBITS  = 300,
    parameter int PSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DBITS-1:0]  disp_i,
    input  logic              four_i,
    input  logic              half_i,
    input  logic              segoff_i,
    input  logic [PSEL_W-1:0] psel_i,
    input  logic              wave_en_i,
    input  logic              port_en_i,
    input  logic [1:0]        com_idx_i,
    input  logic              neg_i,
    output logic [5:0]        com_o,
    output logic [NSEG*2-1:0] seg_o
);
    localparam int DUAL = NSEG - 3;
    localparam int DBW  = $clog2(DBITS);

    logic [PSEL_W-1:0] pcnt;
    assign pcnt = (psel_i > PSEL_W'(NPORT)) ? PSEL_W'(NPORT) : psel_i;

    for (genvar c = 0; c < 3; c++) begin : g_com
        always_comb begin
            if (wave_en_i)
                com_o[c*2 +: 2] = lvl_com(com_idx_i == 2'(c), neg_i, half_i);
            else
                com_o[c*2 +: 2] = LV_GND;
        end
    end

    for (genvar j = 0; j < NSEG; j++) begin : g_seg
        localparam int  K4      = (j > DUAL) ? j - 1 : j;
        localparam bit  IS_DUAL = (j == DUAL);
        logic [DBW-1:0] idx;
        logic           lit;
        lvl_e           lvl;

        always_comb begin
            if (four_i)
                idx = DBW'(K4 * 4) + DBW'(com_idx_i);
            else
                idx = DBW'(j * 3) + DBW'(com_idx_i);
            lit = disp_i[idx] & ~segoff_i;
            if (!wave_en_i)
                lvl = LV_GND;
            else if (four_i && IS_DUAL)
                lvl = lvl_com(com_idx_i == 2'd3, neg_i, half_i);
            else
                lvl = lvl_seg(lit, neg_i, half_i);
        end

        if (j < NPORT) begin : g_port
            logic pbit;
            logic is_port;
            assign pbit    = four_i ? disp_i[j*4] : disp_i[j*3];
            assign is_port = port_en_i && (pcnt > PSEL_W'(j));
            assign seg_o[j*2 +: 2] = is_port ? (pbit ? LV_TOP : LV_GND) : lvl;

            // R9: a port pin is static while its inputs hold still
            a_r9_port_static: assert property (@(posedge clk) disable iff (!rst_n)
                (is_port && $past(is_port) && $stable(disp_i) && $stable(four_i))
                    |-> $stable(seg_o[j*2 +: 2]));
        end else begin : g_plain
            assign seg_o[j*2 +: 2] = lvl;
        end
    end

endmodule

// File: rtl/lcdseq_top.sv
module lcdseq_top
    import lcdseq_pkg::*;
#(
    parameter int NSEG        = 76,
    parameter int NPORT       = 8,
    parameter int FRAME_TICKS = 384,
    localparam int DBITS  = (4 * (NSEG - 1) > 3 * NSEG) ? 4 * (NSEG - 1) : 3 * NSEG,
    localparam int PSEL_W = $clog2(NPORT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              hold_i,
    input  logic              sleep_i,
    input  logic              duty_i,
    input  logic              bias_i,
    input  logic              segoff_i,
    input  logic [PSEL_W-1:0] psel_i,
    input  logic [DBITS-1:0]  disp_i,
    output logic [5:0]        com_o,
    output logic [NSEG*2-1:0] seg_o
);
    state_e state_q, state_d;

    logic              wave_en, port_en, sh_clr, sh_load;
    logic              frame_end;
    logic [1:0]        com_idx;
    logic              neg;
    logic [DBITS-1:0]  sh_disp;
    logic              sh_four, sh_half, sh_soff;
    logic [PSEL_W-1:0] sh_psel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HOLD;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (hold_i) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:  state_d = ST_IDLE;
                ST_IDLE:  if (sleep_i) state_d = ST_SLEEP;
                          else if (tick_i) state_d = ST_DRIVE;
                ST_DRIVE: if (sleep_i) state_d = ST_SLEEP;
                ST_SLEEP: if (!sleep_i) state_d = ST_IDLE;
            endcase
        end
    end

    // per-state controls
    always_comb begin
        wave_en = 1'b0;
        port_en = 1'b0;
        sh_clr  = 1'b0;
        sh_load = 1'b0;
        unique case (state_q)
            ST_HOLD:  sh_clr = 1'b1;
            ST_IDLE:  begin port_en = 1'b1; sh_load = 1'b1; end
            ST_DRIVE: begin wave_en = 1'b1; port_en = 1'b1; sh_load = frame_end; end
            ST_SLEEP: begin port_en = 1'b1; sh_load = 1'b1; end
        endcase
    end

    lcdseq_timer #(
        .FRAME_TICKS (FRAME_TICKS)
    ) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (wave_en),
        .tick_i      (tick_i),
        .four_i      (sh_four),
        .com_idx_o   (com_idx),
        .neg_o       (neg),
        .frame_end_o (frame_end)
    );

    lcdseq_shadow #(
        .DBITS  (DBITS),
        .PSEL_W (PSEL_W)
    ) shadow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (sh_clr),
        .load_i   (sh_load),
        .disp_i   (disp_i),
        .duty_i   (duty_i),
        .bias_i   (bias_i),
        .segoff_i (segoff_i),
        .psel_i   (psel_i),
        .disp_o   (sh_disp),
        .four_o   (sh_four),
        .half_o   (sh_half),
        .segoff_o (sh_soff),
        .psel_o   (sh_psel)
    );

    lcdseq_pinmap #(
        .NSEG   (NSEG),
        .NPORT  (NPORT),
        .DBITS  (DBITS),
        .PSEL_W (PSEL_W)
    ) pinmap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_i    (sh_disp),
        .four_i    (sh_four),
        .half_i    (sh_half),
        .segoff_i  (sh_soff),
        .psel_i    (sh_psel),
        .wave_en_i (wave_en),
        .port_en_i (port_en),
        .com_idx_i (com_idx),
        .neg_i     (neg),
        .com_o     (com_o),
        .seg_o     (seg_o)
    );

    // R1: a sampled hold blanks every pin on the next edge
    a_r1_hold_dark: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (com_o == '0 && seg_o == '0));

    // R8: a sampled sleep request leaves the commons at ground
    a_r8_sleep_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !hold_i) |=> (com_o == '0));

endmodule

// File: tb/lcdseq_top_tb_top.sv
module lcdseq_top_tb_top;
    localparam int NSEG  = 76;
    localparam int DBITS = 300;
    localparam int SW    = NSEG * 2;
    localparam int NV    = 11;

    // {duty, bias, segoff, psel[3:0], pattern[1:0], slot[2:0]}
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 3'd0},
        {1'b0, 1'b0, 1'b0, 4'd0,  2'd1, 3'd2},
        {1'b0, 1'b0, 1'b0, 4'd0,  2'd2, 3'd5},
        {1'b0, 1'b1, 1'b0, 4'd0,  2'd0, 3'd3},
        {1'b1, 1'b0, 1'b0, 4'd0,  2'd2, 3'd1},
        {1'b1, 1'b0, 1'b0, 4'd0,  2'd1, 3'd4},
        {1'b1, 1'b1, 1'b0, 4'd5,  2'd3, 3'd2},
        {1'b0, 1'b0, 1'b1, 4'd0,  2'd3, 3'd1},
        {1'b0, 1'b0, 1'b1, 4'd3,  2'd0, 3'd6},
        {1'b1, 1'b0, 1'b0, 4'd12, 2'd2, 3'd0},
        {1'b0, 1'b1, 1'b0, 4'd8,  2'd1, 3'd7}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b1;
    logic             hold = 1'b1;
    logic             sleep = 1'b0;
    logic             duty = 1'b0;
    logic             bias = 1'b0;
    logic             soff = 1'b0;
    logic [3:0]       psel = 4'd0;
    logic [DBITS-1:0] disp = '0;
    logic [5:0]       com;
    logic [SW-1:0]    seg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lcdseq_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .hold_i   (hold),
        .sleep_i  (sleep),
        .duty_i   (duty),
        .bias_i   (bias),
        .segoff_i (soff),
        .psel_i   (psel),
        .disp_i   (disp),
        .com_o    (com),
        .seg_o    (seg)
    );

    function automatic logic [DBITS-1:0] mk(input int p);
        logic [DBITS-1:0] d = '0;
        for (int i = 0; i < DBITS; i++) begin
            case (p)
                0:       d[i] = (i % 2) == 0;
                1:       d[i] = (i % 3) == 0;
                2:       d[i] = ((i * 7 + 3) % 5) < 2;
                default: d[i] = 1'b1;
            endcase
        end
        return d;
    endfunction

    function automatic logic [SW-1:0] exp_segs(input bit dty, input bit hb, input bit so,
                                               input int ps, input int slot,
                                               input logic [DBITS-1:0] d,
                                               input bit wave, input bit ports);
        int nc = dty ? 3 : 4;
        int c  = slot % nc;
        bit ng = slot >= nc;
        int pc = (ps > 8) ? 8 : ps;
        logic [SW-1:0] r = '0;
        for (int j = 0; j < NSEG; j++) begin
            logic [1:0] v;
            int k;
            if (ports && j < pc)
                v = d[j*nc] ? 2'd3 : 2'd0;
            else if (!wave)
                v = 2'd0;
            else if (nc == 4 && j == NSEG - 3)
                v = (c == 3) ? (ng ? 2'd0 : 2'd3) : (hb ? 2'd1 : (ng ? 2'd2 : 2'd1));
            else begin
                k = (nc == 4 && j > NSEG - 3) ? j - 1 : j;
                if (!so && d[k*nc + c])
                    v = ng ? 2'd3 : 2'd0;
                else
                    v = hb ? 2'd1 : (ng ? 2'd1 : 2'd2);
            end
            r[j*2 +: 2] = v;
        end
        return r;
    endfunction

    function automatic logic [5:0] exp_coms(input bit dty, input bit hb, input int slot,
                                            input bit wave);
        int nc = dty ? 3 : 4;
        int c  = slot % nc;
        bit ng = slot >= nc;
        logic [5:0] r = '0;
        for (int i = 0; i < 3; i++) begin
            if (!wave)
                r[i*2 +: 2] = 2'd0;
            else if (i == c)
                r[i*2 +: 2] = ng ? 2'd0 : 2'd3;
            else
                r[i*2 +: 2] = hb ? 2'd1 : (ng ? 2'd2 : 2'd1);
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [SW-1:0] got, input logic [SW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic adv(input int m);
        repeat (m) @(posedge clk);
        @(negedge clk);
    endtask

    // apply hold, load a setup, release: returns just after the edge that enters DRIVE
    task automatic launch(input bit dty, input bit hb, input bit so, input logic [3:0] ps,
                          input logic [DBITS-1:0] d);
        @(negedge clk);
        hold = 1'b1; sleep = 1'b0; tick = 1'b1;
        duty = dty; bias = hb; soff = so; psel = ps; disp = d;
        @(negedge clk);
        hold = 1'b0;
        @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset segments", seg, '0);
        chk("R1 reset commons", SW'(com), '0);

        for (int v = 0; v < NV; v++) begin
            logic [11:0] e;
            bit dt, hb, so;
            int ps, pt, sl, sz;
            string tag;
            e  = VEC[v];
            dt = e[11]; hb = e[10]; so = e[9];
            ps = int'(e[8:5]); pt = int'(e[4:3]); sl = int'(e[2:0]);
            sz = dt ? 64 : 48;
            tag = so ? "R7" : (ps != 0) ? "R9" : hb ? "R5" : dt ? "R3" : "R4";
            launch(dt, hb, so, 4'(ps), mk(pt));
            adv(sl * sz + sz / 2);
            chk({tag, " R6 segments"}, seg, exp_segs(dt, hb, so, ps, sl, mk(pt), 1'b1, 1'b1));
            chk({tag, " R2 commons"}, SW'(com), SW'(exp_coms(dt, hb, sl, 1'b1)));
        end

        // R10: data changed mid-frame waits for the frame boundary
        launch(1'b0, 1'b0, 1'b0, 4'd0, mk(0));
        adv(100);
        disp = mk(2);
        adv(280);
        chk("R10 old data to frame end", seg, exp_segs(0, 0, 0, 0, 7, mk(0), 1, 1));
        adv(10);
        chk("R10 new data after boundary", seg, exp_segs(0, 0, 0, 0, 0, mk(2), 1, 1));
        chk("R10 commons restart slot 0", SW'(com), SW'(exp_coms(0, 0, 0, 1)));

        // R11: counters freeze without ticks
        launch(1'b0, 1'b0, 1'b0, 4'd0, mk(1));
        adv(10);
        tick = 1'b0;
        adv(300);
        chk("R11 frozen commons", SW'(com), SW'(exp_coms(0, 0, 0, 1)));
        chk("R11 frozen segments", seg, exp_segs(0, 0, 0, 0, 0, mk(1), 1, 1));
        tick = 1'b1;
        adv(48);
        chk("R11 resumed commons", SW'(com), SW'(exp_coms(0, 0, 1, 1)));
        chk("R11 resumed segments", seg, exp_segs(0, 0, 0, 0, 1, mk(1), 1, 1));

        // R8: sleep darkens the panel but keeps ports live
        launch(1'b0, 1'b0, 1'b0, 4'd3, mk(3));
        adv(24);
        chk("R9 ports while driving", seg, exp_segs(0, 0, 0, 3, 0, mk(3), 1, 1));
        sleep = 1'b1;
        adv(1);
        chk("R8 sleep segments", seg, exp_segs(0, 0, 0, 3, 0, mk(3), 0, 1));
        chk("R8 sleep commons", SW'(com), '0);
        disp = mk(1);
        adv(1);
        chk("R8 ports follow data in sleep", seg, exp_segs(0, 0, 0, 3, 0, mk(1), 0, 1));
        sleep = 1'b0;
        adv(2);
        adv(24);
        chk("R8 wake segments", seg, exp_segs(0, 0, 0, 3, 0, mk(1), 1, 1));
        chk("R8 wake commons", SW'(com), SW'(exp_coms(0, 0, 0, 1)));

        // R1: hold while driving blanks every pin, ports too
        disp = mk(3);
        hold = 1'b1;
        adv(1);
        chk("R1 hold segments", seg, '0);
        chk("R1 hold commons", SW'(com), '0);
        hold = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule